// File: doc/BRIEF.md
# Amplifier Control and Diagnostic I2C Slave

This block is the two-wire serial control port of a four-channel audio power amplifier. A fast system clock oversamples the bus clock and data lines. From them the block picks out start and stop conditions, receives bytes MSB first, and answers the ninth clock of each byte with an acknowledge when that byte concerns it. There is no register subaddress. A write transaction always fills the two instruction registers in a fixed order. A read transaction always streams a fixed sequence of four diagnostic bytes, one for each output channel.

The instruction registers drive a set of decoded control outputs: converter switching frequency, regulated voltage choice, converter enable, per-pair gain and mute, clip threshold, offset-test start, standby release and high-efficiency mode for each side. The diagnostic bytes are assembled from per-channel offset and short-circuit flags and from a few chip-wide flags. All status inputs are captured in one cycle when a read address is acknowledged. The bus may run at up to 400 kHz, provided the system clock is at least sixteen times the bus clock rate.

Top module: `amp_i2c_ctl`

## Requirements
- R1: A start is a high-to-low edge of SDA while SCL is high, and it restarts address reception from any state. A stop is a low-to-high edge of SDA while SCL is high, and it returns the slave to idle with SDA released.
- R2: The slave changes its SDA drive only while SCL is low, except when a start or stop forces the release.
- R3: The slave pulls SDA low during the ninth clock of the address byte only when address bits 7..1 equal DEV_ADDR (default 7'h6C). Address bit 0 picks the direction: 0 means write and 1 means read. On a mismatch the slave acknowledges nothing, drives nothing and changes no register until the next start.
- R4: In a write, the first data byte goes to instruction register 1 and the second to instruction register 2, and each is acknowledged. A third or later byte is not acknowledged and has no effect.
- R5: An instruction register changes only when its whole byte has been received and acknowledged. A stop in the middle of a byte leaves that register unchanged.
- R6: After reset both instruction registers are zero. Every control output is therefore 0: the amplifier is in standby and both channel pairs are muted.
- R7: Instruction register 1 decodes as follows. sw_freq_o = bits 7:6. offset_det_o = bit 5. front_gain12_o = bit 4 and rear_gain12_o = bit 3 (1 selects 12 dB, 0 selects 26 dB). front_unmute_o = bit 2 and rear_unmute_o = bit 1. clip_thr10_o = bit 0 (1 selects 10 %, 0 selects 1 %).
- R8: Instruction register 2 decodes as follows. conv_en_o = bit 7. vreg_sel_o = {bit 6, bit 3}. amp_on_o = bit 4 (1 leaves standby). hieff_right_o = bit 1 and hieff_left_o = bit 0.
- R9: A read returns bytes k = 0, 1, 2, 3 in order for channels LF, LR, RF and RR, where channel k is index k of the flag inputs. In byte k, bit 2 is offset_flag_i[k] and bit 1 is short_flag_i[k]. Byte 0 bit 7 is therm_warn_i. Byte 1 bit 7 is off_stat_i and byte 1 bit 5 is clip_i. Byte 2 bit 7 is stby_stat_i. Every other bit is 0.
- R10: The status inputs are sampled once, when a read address is accepted. Changes made after that point do not alter the bytes of that read.
- R11: When the master answers a read byte with a NACK, the slave releases SDA and stays off the bus until the next start, so further clocked bytes read as all ones.
- R12: A repeated start in the middle of a byte discards that partial byte, and the address that follows is received and acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as resolved on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| offset_flag_i | input | 4 | Per-channel DC offset flags, index 0..3 = LF, LR, RF, RR |
| short_flag_i | input | 4 | Per-channel short-circuit flags, same indexing |
| therm_warn_i | input | 1 | Thermal warning flag |
| off_stat_i | input | 1 | Off status flag |
| clip_i | input | 1 | Clip detector output |
| stby_stat_i | input | 1 | Standby status flag |
| sw_freq_o | output | 2 | Converter switching frequency select |
| offset_det_o | output | 1 | Start offset detection |
| front_gain12_o | output | 1 | Front pair low gain |
| rear_gain12_o | output | 1 | Rear pair low gain |
| front_unmute_o | output | 1 | Front pair unmuted |
| rear_unmute_o | output | 1 | Rear pair unmuted |
| clip_thr10_o | output | 1 | Clip detector at the 10 % threshold |
| conv_en_o | output | 1 | Voltage converter enable |
| vreg_sel_o | output | 2 | Regulated voltage select |
| amp_on_o | output | 1 | Amplifier out of standby |
| hieff_right_o | output | 1 | Right channels in high-efficiency mode |
| hieff_left_o | output | 1 | Left channels in high-efficiency mode |

## Verification
Two events can fall in the same cycle. One is the falling SCL edge that ends an acknowledge clock: it commits a write byte or loads the next read byte. The other is the bus start and stop logic, which is fed through the same synchronizers and can override the byte engine. The bench provokes this overlap with a stop inside a byte, with a repeated start three bits into a data byte, and with a full write run at the minimum sixteen-to-one clock ratio, where the commit lands only a few system cycles before the next SCL rise. In each case the bench model's expected register image is compared against the decoded outputs on every clock while SCL is high. A separate monitor flags any change of the SDA drive that happens while SCL is high outside a start or stop.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;
  localparam int unsigned N_CH     = 4;
  localparam int unsigned N_WR     = 2;
  localparam int unsigned N_RD     = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned IDX_W    = $clog2(N_RD);
  localparam int unsigned CNT_W    = $clog2(BYTE_W + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK, S_IGNORE
  } bus_st_e;

  typedef struct packed {
    logic [1:0] sw_freq;
    logic       offset_det;
    logic       front_gain12;
    logic       rear_gain12;
    logic       front_unmute;
    logic       rear_unmute;
    logic       clip_thr10;
    logic       conv_en;
    logic [1:0] vreg_sel;
    logic       amp_on;
    logic       hieff_right;
    logic       hieff_left;
  } ctl_t;

  typedef struct packed {
    logic [N_CH-1:0] offset;
    logic [N_CH-1:0] short_c;
    logic            therm_warn;
    logic            off_stat;
    logic            clip;
    logic            stby_stat;
  } stat_t;
endpackage

// File: rtl/amp_i2c_sync.sv
module amp_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_o;
    end
  end

  assign scl_s   = scl_pipe[STAGES-1];
  assign sda_o   = sda_pipe[STAGES-1];
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
  // SCL steady high across the SDA edge
  assign start_o = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/amp_i2c_engine.sv
module amp_i2c_engine
  import amp_i2c_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h6C
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sda_s_i,
  input  logic                         rise_i,
  input  logic                         fall_i,
  input  logic                         start_i,
  input  logic                         stop_i,
  input  logic [N_RD-1:0][BYTE_W-1:0]  rd_bytes_i,
  output logic                         sda_oe_o,
  output logic                         wr_en_o,
  output logic [IDX_W-1:0]             wr_idx_o,
  output byte_t                        wr_data_o,
  output logic                         snap_en_o
);
  bus_st_e          st_q;
  logic [CNT_W-1:0] bit_cnt_q;
  byte_t            rx_q, tx_q;
  logic             oe_q, rw_q;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic             byte_done, addr_hit, wr_slot_ok;

  assign byte_done  = fall_i && (bit_cnt_q == CNT_W'(BYTE_W));
  assign addr_hit   = (rx_q[BYTE_W-1:1] == DEV_ADDR);
  assign wr_slot_ok = (idx_q < IDX_W'(N_WR));
  assign nxt_idx    = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      idx_q     <= '0;
    end else if (start_i) begin
      st_q      <= S_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      idx_q     <= '0;
    end else if (stop_i) begin
      st_q <= S_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_ADDR, S_WR: begin
          if (rise_i && bit_cnt_q != CNT_W'(BYTE_W)) begin
            rx_q      <= {rx_q[BYTE_W-2:0], sda_s_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            if (st_q == S_ADDR) begin
              if (addr_hit) begin
                oe_q <= 1'b1;
                rw_q <= rx_q[0];
                st_q <= S_ADDR_ACK;
              end else begin
                st_q <= S_IGNORE;
              end
            end else if (wr_slot_ok) begin
              oe_q <= 1'b1;
              st_q <= S_WR_ACK;
            end else begin
              st_q <= S_IGNORE;
            end
          end
        end
        S_ADDR_ACK: begin
          if (fall_i) begin
            bit_cnt_q <= '0;
            idx_q     <= '0;
            if (rw_q) begin
              st_q <= S_RD;
              tx_q <= rd_bytes_i[0];
              oe_q <= ~rd_bytes_i[0][BYTE_W-1];
            end else begin
              st_q <= S_WR;
              oe_q <= 1'b0;
            end
          end
        end
        S_WR_ACK: begin
          if (fall_i) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            idx_q     <= nxt_idx;
            st_q      <= S_WR;
          end
        end
        S_RD: begin
          if (rise_i) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (fall_i) begin
            if (bit_cnt_q == CNT_W'(BYTE_W)) begin
              oe_q <= 1'b0;
              st_q <= S_RD_ACK;
            end else begin
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q <= ~tx_q[BYTE_W-2];
            end
          end
        end
        S_RD_ACK: begin
          if (rise_i && sda_s_i) begin
            st_q <= S_IGNORE;
          end else if (fall_i) begin
            bit_cnt_q <= '0;
            idx_q     <= nxt_idx;
            tx_q      <= rd_bytes_i[nxt_idx];
            oe_q      <= ~rd_bytes_i[nxt_idx][BYTE_W-1];
            st_q      <= S_RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = (st_q == S_WR_ACK) && fall_i;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = rx_q;
  assign snap_en_o = (st_q == S_ADDR) && byte_done && addr_hit && rx_q[0];

  a_r1_start_to_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == S_ADDR));
  a_r1_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  a_r2_drive_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(fall_i || start_i || stop_i));
  a_r5_commit_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(sda_oe_o));
  a_r4_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o < IDX_W'(N_WR)));
  a_r11_nack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RD_ACK && rise_i && sda_s_i && !start_i && !stop_i)
      |=> (!sda_oe_o && st_q == S_IGNORE));
endmodule

// File: rtl/amp_ctl_regs.sv
module amp_ctl_regs
  import amp_i2c_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  byte_t                        wr_data_i,
  input  logic                         snap_en_i,
  input  stat_t                        stat_i,
  output ctl_t                         ctl_o,
  output logic [N_RD-1:0][BYTE_W-1:0]  rd_bytes_o
);
  logic [N_WR-1:0][BYTE_W-1:0] ir_q;
  stat_t stat_q;
  byte_t ir1, ir2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < N_WR; k++)
        if (wr_idx_i == IDX_W'(k)) ir_q[k] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_q <= '0;
    else if (snap_en_i) stat_q <= stat_i;
  end

  assign ir1 = ir_q[0];
  assign ir2 = ir_q[1];

  always_comb begin
    ctl_o              = '0;
    ctl_o.sw_freq      = ir1[7:6];
    ctl_o.offset_det   = ir1[5];
    ctl_o.front_gain12 = ir1[4];
    ctl_o.rear_gain12  = ir1[3];
    ctl_o.front_unmute = ir1[2];
    ctl_o.rear_unmute  = ir1[1];
    ctl_o.clip_thr10   = ir1[0];
    ctl_o.conv_en      = ir2[7];
    ctl_o.vreg_sel     = {ir2[6], ir2[3]};
    ctl_o.amp_on       = ir2[4];
    ctl_o.hieff_right  = ir2[1];
    ctl_o.hieff_left   = ir2[0];
  end

  for (genvar ch = 0; ch < N_RD; ch++) begin : g_stat_byte
    logic top_bit, clip_bit;
    if (ch == 0)      begin : g_b0 assign top_bit = stat_q.therm_warn; end
    else if (ch == 1) begin : g_b1 assign top_bit = stat_q.off_stat;   end
    else if (ch == 2) begin : g_b2 assign top_bit = stat_q.stby_stat;  end
    else              begin : g_bn assign top_bit = 1'b0;              end
    if (ch == 1) begin : g_c1 assign clip_bit = stat_q.clip; end
    else         begin : g_cn assign clip_bit = 1'b0;        end
    assign rd_bytes_o[ch] = {top_bit, 1'b0, clip_bit, 2'b00,
                             stat_q.offset[ch], stat_q.short_c[ch], 1'b0};
  end

  a_r5_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ir_q));
  a_r10_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_en_i |=> $stable(stat_q));
endmodule

// File: rtl/amp_i2c_ctl.sv
module amp_i2c_ctl
  import amp_i2c_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h6C,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [N_CH-1:0] offset_flag_i,
  input  logic [N_CH-1:0] short_flag_i,
  input  logic            therm_warn_i,
  input  logic            off_stat_i,
  input  logic            clip_i,
  input  logic            stby_stat_i,
  output logic [1:0]      sw_freq_o,
  output logic            offset_det_o,
  output logic            front_gain12_o,
  output logic            rear_gain12_o,
  output logic            front_unmute_o,
  output logic            rear_unmute_o,
  output logic            clip_thr10_o,
  output logic            conv_en_o,
  output logic [1:0]      vreg_sel_o,
  output logic            amp_on_o,
  output logic            hieff_right_o,
  output logic            hieff_left_o
);
  logic sda_s, rise, fall, start, stop;
  logic wr_en, snap_en;
  logic [IDX_W-1:0] wr_idx;
  byte_t wr_data;
  logic [N_RD-1:0][BYTE_W-1:0] rd_bytes;
  stat_t stat;
  ctl_t  ctl;

  assign stat = '{offset: offset_flag_i, short_c: short_flag_i,
                  therm_warn: therm_warn_i, off_stat: off_stat_i,
                  clip: clip_i, stby_stat: stby_stat_i};

  amp_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .rise_o(rise), .fall_o(fall), .start_o(start), .stop_o(stop)
  );

  amp_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .rise_i(rise), .fall_i(fall),
    .start_i(start), .stop_i(stop), .rd_bytes_i(rd_bytes),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .snap_en_o(snap_en)
  );

  amp_ctl_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .snap_en_i(snap_en), .stat_i(stat), .ctl_o(ctl), .rd_bytes_o(rd_bytes)
  );

  assign sw_freq_o      = ctl.sw_freq;
  assign offset_det_o   = ctl.offset_det;
  assign front_gain12_o = ctl.front_gain12;
  assign rear_gain12_o  = ctl.rear_gain12;
  assign front_unmute_o = ctl.front_unmute;
  assign rear_unmute_o  = ctl.rear_unmute;
  assign clip_thr10_o   = ctl.clip_thr10;
  assign conv_en_o      = ctl.conv_en;
  assign vreg_sel_o     = ctl.vreg_sel;
  assign amp_on_o       = ctl.amp_on;
  assign hieff_right_o  = ctl.hieff_right;
  assign hieff_left_o   = ctl.hieff_left;
endmodule

// File: tb/amp_i2c_ctl_bench.sv
module amp_i2c_ctl_bench;
  localparam logic [6:0] ADDR = 7'h6C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, in_cond = 1'b0;
  logic [3:0] off_f = '0, sh_f = '0;
  logic tw = 0, os = 0, cl = 0, ss = 0;
  logic sda_oe;
  logic [1:0] sw_freq, vreg_sel;
  logic offset_det, fg12, rg12, fun, run, clip10, conv, amp_on, her, hel;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, q = 10;
  logic [7:0] ir1_m = '0, ir2_m = '0;

  amp_i2c_ctl u_amp_i2c_ctl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .offset_flag_i(off_f), .short_flag_i(sh_f), .therm_warn_i(tw), .off_stat_i(os),
    .clip_i(cl), .stby_stat_i(ss), .sw_freq_o(sw_freq), .offset_det_o(offset_det),
    .front_gain12_o(fg12), .rear_gain12_o(rg12), .front_unmute_o(fun),
    .rear_unmute_o(run), .clip_thr10_o(clip10), .conv_en_o(conv),
    .vreg_sel_o(vreg_sel), .amp_on_o(amp_on), .hieff_right_o(her), .hieff_left_o(hel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_ctl(input logic [7:0] a, input logic [7:0] b);
    // R7 fields, then R8 fields
    return {a[7:6], a[5], a[4], a[3], a[2], a[1], a[0], b[7], b[6], b[3], b[4], b[1], b[0]};
  endfunction

  function automatic logic [7:0] exp_stat(input int k);
    logic b7, b5;
    b7 = (k == 0) ? tw : (k == 1) ? os : (k == 2) ? ss : 1'b0;
    b5 = (k == 1) ? cl : 1'b0;
    return {b7, 1'b0, b5, 2'b00, off_f[k], sh_f[k], 1'b0};
  endfunction

  wire [14:0] got_ctl = {sw_freq, offset_det, fg12, rg12, fun, run, clip10,
                         conv, vreg_sel, amp_on, her, hel};

  // reference comparison on every clock while SCL is high (R7, R8)
  always @(negedge clk)
    if (rst_n && scl_m)
      check(got_ctl == exp_ctl(ir1_m, ir2_m), "R7 R8 decode", 32'(got_ctl),
            32'(exp_ctl(ir1_m, ir2_m)));

  // R2: slave drive may move only while SCL is low
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && !in_cond)
      check(!scl_m, "R2 drive change with SCL high", 32'(scl_m), 32'(0));
    prev_oe <= sda_oe;
  end

  task automatic wq(); repeat (q) @(negedge clk); endtask

  task automatic bstart();
    in_cond = 1; sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); in_cond = 0;
  endtask

  task automatic bstop();
    in_cond = 1; sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); in_cond = 0;
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1; wq(); s = sda_line; wq(); scl_m = 0; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clock_bit(b[i], s);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); d[i] = s; end
    clock_bit(mack ? 1'b0 : 1'b1, s);
  endtask

  task automatic m_write(input logic [6:0] a, input logic [7:0] d[$]);
    logic ack;
    bit match = (a == ADDR);
    bstart();
    send_byte({a, 1'b0}, ack);
    check(ack == match, "R3 write address ack", 32'(ack), 32'(match));
    foreach (d[i]) begin
      bit e = match && (i < 2);
      send_byte(d[i], ack);
      check(ack == e, "R4 data byte ack", 32'(ack), 32'(e));
      if (e) begin
        if (i == 0) ir1_m = d[i];
        else        ir2_m = d[i];
      end
    end
    bstop();
  endtask

  task automatic m_read(input logic [6:0] a, input int nb, input bit change_after);
    logic ack;
    logic [7:0] d, ex [4];
    bit match = (a == ADDR);
    bstart();
    send_byte({a, 1'b1}, ack);
    check(ack == match, "R3 read address ack", 32'(ack), 32'(match));
    for (int k = 0; k < 4; k++) ex[k] = match ? exp_stat(k) : 8'hFF;
    if (change_after) begin
      off_f = ~off_f; sh_f = ~sh_f; tw = ~tw; os = ~os; cl = ~cl; ss = ~ss;
    end
    for (int k = 0; k < nb; k++) begin
      recv_byte(k < nb - 1, d);
      if (change_after) check(d == ex[k], "R10 snapshot byte", 32'(d), 32'(ex[k]));
      else              check(d == ex[k], "R9 status byte", 32'(d), 32'(ex[k]));
    end
    check(sda_oe == 1'b0, "R11 released after NACK", 32'(sda_oe), 32'(0));
    recv_byte(1'b0, d);
    check(d == 8'hFF, "R11 bus ignored after NACK", 32'(d), 32'hFF);
    bstop();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R6 reset state
    check(got_ctl == '0, "R6 reset outputs", 32'(got_ctl), 32'(0));
    check(sda_oe == 1'b0, "R6 SDA released after reset", 32'(sda_oe), 32'(0));

    m_write(ADDR, '{8'hA5, 8'h93});
    m_write(ADDR, '{8'h5A, 8'h6C});
    m_write(7'h6D, '{8'hFF, 8'hFF});            // R3 mismatch, no change
    check(got_ctl == exp_ctl(8'h5A, 8'h6C), "R3 mismatch leaves registers", 32'(got_ctl),
          32'(exp_ctl(8'h5A, 8'h6C)));
    m_write(ADDR, '{8'h0F, 8'hF0, 8'h33});      // R4 third byte refused

    // R5: stop inside the second data byte
    bstart();
    send_byte({ADDR, 1'b0}, ack);
    check(ack, "R5 address ack", 32'(ack), 32'(1));
    send_byte(8'hC3, ack);
    check(ack, "R5 first byte ack", 32'(ack), 32'(1));
    ir1_m = 8'hC3;
    send_bits(8'h81, 4);
    bstop();
    check(got_ctl == exp_ctl(8'hC3, 8'hF0), "R5 partial byte dropped", 32'(got_ctl),
          32'(exp_ctl(8'hC3, 8'hF0)));

    // R12: repeated start three bits into a data byte
    bstart();
    send_byte({ADDR, 1'b0}, ack);
    send_bits(8'h12, 3);
    m_write(ADDR, '{8'h3C, 8'hC3});
    check(got_ctl == exp_ctl(8'h3C, 8'hC3), "R12 repeated start", 32'(got_ctl),
          32'(exp_ctl(8'h3C, 8'hC3)));

    // R1 R7 R8 at the minimum 16:1 clock ratio
    q = 4;
    m_write(ADDR, '{8'h96, 8'h69});
    q = 10;
    check(sda_oe == 1'b0, "R1 idle after stop", 32'(sda_oe), 32'(0));

    off_f = 4'b1010; sh_f = 4'b0101; tw = 1; os = 0; cl = 1; ss = 1;
    m_read(ADDR, 4, 1'b0);
    off_f = 4'b0101; sh_f = 4'b1010; tw = 0; os = 1; cl = 0; ss = 0;
    m_read(ADDR, 4, 1'b0);
    m_read(ADDR, 4, 1'b1);                       // R10
    m_read(ADDR, 1, 1'b0);                       // R11 early NACK
    m_read(7'h2C, 2, 1'b0);                      // R3 read to another address
    m_write(ADDR, '{8'h00, 8'h00});              // back to standby, R6 values
    check(got_ctl == '0, "R6 standby restored", 32'(got_ctl), 32'(0));
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule